// File: doc/BRIEF.md
# PCI Interrupt Status and Mask Unit

This block gathers interrupt events from the PCI side of a chip into one status register. It gates them through a per-bit mask register and a global enable bit, and drives one level-sensitive interrupt line toward the CPU. Each event input is a single-cycle pulse or a held level. Any cycle in which an input is high latches its status bit. Descriptor-chain events use the low sixteen bits. The external PCI INTA line lands in bit 25 and a bus abort lands in bit 26.

Software reaches the three registers through a plain 32-bit word-addressed read/write port. It clears status bits by writing ones. Alongside the line, the block presents the masked "pending" vector and a fixed-priority index of the winning source. A downstream demultiplexer can use these to dispatch without reading the registers. The lowest-numbered pending bit wins, so external INTA is served before a bus abort.

Top module: `pci_irq_ctrl`

## Requirements
- R1: While reset is held, and right after it, status, mask and global enable all read zero, the pending vector is zero, the interrupt line is low, the pending-any flag is low and the index is 0.
- R2: An event input that is high at a rising clock edge sets its status bit, and that bit stays set until software clears it. Status lives at byte offset 0x500 (word address 0x140). External INTA uses bit 25, bus abort uses bit 26, and descriptor events use bits 0 to 15.
- R3: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing a 1 never sets a status bit.
- R4: When an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register at byte offset 0x504 (word 0x141) stores and returns all 32 bits. The global enable at byte offset 0x508 (word 0x142) stores only bit 0, and its other bits read as 0.
- R6: The pending output equals status AND mask, bit for bit.
- R7: The interrupt line is high exactly while the global enable bit is 1 and at least one pending bit is set. With enable 0 it is low whatever status and mask hold. This output is combinational from the registers by default.
- R8: The index output gives the lowest-numbered pending bit, so INTA (25) wins over abort (26). When nothing is pending, the pending-any flag is 0 and the index is 0.
- R9: A write to any other word address changes no register, and a read from any other word address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NSRC (32) | Event inputs, one per status bit |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (10) | Word address for read and write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| pend_vec | output | NSRC (32) | Status AND mask |
| pend_any | output | 1 | At least one pending bit |
| pend_idx | output | IDX_W (5) | Lowest-numbered pending bit |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit data path, a 10-bit word address and the combinational interrupt output. With 32 sources the INTA and abort bits and the descriptor bits 0 to 4 all exist, so the INTA-over-abort order can be exercised on the real bit positions. The combinational output also lets the line be checked in the same cycle that status or enable changes. An unmapped word just past the enable register is used to show that stray accesses reach nothing.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // Register selected by a word address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2,
      SEL_GEN  = 2'd3
   } reg_sel_e;

   // Lowest set bit of a 32-bit vector, or 0 when none is set
   function automatic int unsigned lowest_set(input logic [31:0] v);
      int unsigned r;
      r = 0;
      for (int i = 31; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction
endpackage

// File: rtl/pirq_addr_dec.sv
module pirq_addr_dec
   import pirq_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int STAT_WA = 'h140,
   parameter int MASK_WA = 'h141,
   parameter int GEN_WA  = 'h142
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_WA);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_WA);
   localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(GEN_WA);

   always_comb begin
      if (addr == A_STAT)      sel = SEL_STAT;
      else if (addr == A_MASK) sel = SEL_MASK;
      else if (addr == A_GEN)  sel = SEL_GEN;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/pirq_regbank.sv
module pirq_regbank
   import pirq_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [NSRC-1:0]   stat_q,
   output logic [NSRC-1:0]   mask_q,
   output logic              gen_q
);
   logic [NSRC-1:0] clr_bits;
   logic [NSRC-1:0] stat_d;

   // Clear bits come only from a status write; events are ORed in last, so they win
   assign clr_bits = (wr_en && sel == SEL_STAT) ? wdata[NSRC-1:0] : '0;
   assign stat_d   = (stat_q & ~clr_bits) | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         gen_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         if (wr_en && sel == SEL_MASK) mask_q <= wdata[NSRC-1:0];
         if (wr_en && sel == SEL_GEN)  gen_q  <= wdata[0];
      end
   end
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
   parameter int NSRC  = 32,
   parameter int IDX_W = 5
) (
   input  logic [NSRC-1:0]  pend,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   // Scan from the top down so the lowest set bit is the last one assigned
   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

   assign any = |pend;
endmodule

// File: rtl/pci_irq_ctrl.sv
module pci_irq_ctrl
   import pirq_pkg::*;
#(
   parameter int NSRC      = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 10,
   parameter int STAT_BYTE = 'h500,
   parameter int MASK_BYTE = 'h504,
   parameter int GEN_BYTE  = 'h508,
   parameter bit IRQ_REG   = 1'b0,
   localparam int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_evt,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NSRC-1:0]   pend_vec,
   output logic              pend_any,
   output logic [IDX_W-1:0]  pend_idx,
   output logic              irq_out
);
   localparam int STAT_WA = STAT_BYTE / 4;
   localparam int MASK_WA = MASK_BYTE / 4;
   localparam int GEN_WA  = GEN_BYTE / 4;

   // Elaboration-time parameter checks
   if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
      $error("NSRC must lie in 1..DATA_W");
   end
   if ((STAT_BYTE % 4) != 0 || (MASK_BYTE % 4) != 0 || (GEN_BYTE % 4) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (STAT_WA == MASK_WA || STAT_WA == GEN_WA || MASK_WA == GEN_WA) begin : g_bad_overlap
      $error("register offsets must be distinct");
   end
   if (STAT_WA >= (1 << ADDR_W) || MASK_WA >= (1 << ADDR_W) || GEN_WA >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for register offsets");
   end

   reg_sel_e        sel;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] mask_q;
   logic            gen_q;
   logic            irq_d;

   pirq_addr_dec #(
      .ADDR_W (ADDR_W),
      .STAT_WA(STAT_WA),
      .MASK_WA(MASK_WA),
      .GEN_WA (GEN_WA)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   pirq_regbank #(
      .NSRC  (NSRC),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (src_evt),
      .wr_en (reg_wr),
      .sel   (sel),
      .wdata (reg_wdata),
      .stat_q(stat_q),
      .mask_q(mask_q),
      .gen_q (gen_q)
   );

   assign pend_vec = stat_q & mask_q;

   pirq_prio #(
      .NSRC (NSRC),
      .IDX_W(IDX_W)
   ) u_prio (
      .pend(pend_vec),
      .idx (pend_idx),
      .any (pend_any)
   );

   // Read mux
   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata = DATA_W'(stat_q);
         SEL_MASK: reg_rdata = DATA_W'(mask_q);
         SEL_GEN:  reg_rdata = DATA_W'(gen_q);
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_d = gen_q & pend_any;

   // Output variant: straight from the registers, or one flop later
   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_out = irq_q;
   end else begin : g_irq_comb
      assign irq_out = irq_d;
   end
endmodule

// File: rtl/pci_irq_ctrl_chk.sv
module pci_irq_ctrl_chk
   import pirq_pkg::*;
#(
   parameter int NSRC    = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   src_evt,
   input logic              reg_wr,
   input reg_sel_e          sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [NSRC-1:0]   stat_q,
   input logic [NSRC-1:0]   mask_q,
   input logic              gen_q,
   input logic [NSRC-1:0]   pend_vec,
   input logic              pend_any,
   input logic [IDX_W-1:0]  pend_idx,
   input logic              irq_out
);
   logic stat_wr;
   assign stat_wr = reg_wr && (sel == SEL_STAT);

   // R1: registers are clear in the first cycle out of reset
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stat_q == '0 && mask_q == '0 && !gen_q));

   // R2 / R4: every event seen at an edge is set afterwards, even under a clear
   a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stat_q & $past(src_evt)) == $past(src_evt)));

   // R3: bits written as one without a colliding event are clear afterwards
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stat_wr)) |->
         ((stat_q & $past(reg_wdata[NSRC-1:0] & ~src_evt)) == '0));

   // R2 / R3: without a status write, no status bit drops
   a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(stat_wr)) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R6: pending never shows a masked-off bit
   a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec & ~mask_q) == '0);

   // R8: the index names a pending bit with nothing pending below it
   a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      pend_any |-> (pend_vec[pend_idx] &&
                    ((pend_vec & ((NSRC'(1) << pend_idx) - NSRC'(1))) == '0)));

   // R8: idle index is zero
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_any |-> (pend_idx == '0 && $countones(pend_vec) == 0));

   if (IRQ_REG) begin : g_chk_flop
      // R7: line follows enable and pending one cycle later
      a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (irq_out == $past(gen_q && (pend_vec != '0))));
   end else begin : g_chk_comb
      // R7: line high only with enable on and something pending
      a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out |-> (gen_q && pend_vec != '0));
      // R7: line never missing when enabled and pending
      a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
         (gen_q && pend_vec != '0) |-> irq_out);
   end
endmodule

bind pci_irq_ctrl pci_irq_ctrl_chk #(
   .NSRC   (NSRC),
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .IRQ_REG(IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_evt  (src_evt),
   .reg_wr   (reg_wr),
   .sel      (sel),
   .reg_wdata(reg_wdata),
   .stat_q   (stat_q),
   .mask_q   (mask_q),
   .gen_q    (gen_q),
   .pend_vec (pend_vec),
   .pend_any (pend_any),
   .pend_idx (pend_idx),
   .irq_out  (irq_out)
);

// File: tb/pci_irq_ctrl_bench.sv
module pci_irq_ctrl_bench;
   import pirq_pkg::*;

   localparam int CLK_NS = 10;
   localparam logic [9:0] W_STAT = 10'h140;
   localparam logic [9:0] W_MASK = 10'h141;
   localparam logic [9:0] W_GEN  = 10'h142;
   localparam logic [9:0] W_VOID = 10'h143;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_evt = '0;
   logic        reg_wr = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pend_vec;
   logic        pend_any;
   logic [4:0]  pend_idx;
   logic        irq_out;

   pci_irq_ctrl u_pci_irq_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_evt  (src_evt),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .pend_vec (pend_vec),
      .pend_any (pend_any),
      .pend_idx (pend_idx),
      .irq_out  (irq_out)
   );

   always #(CLK_NS / 2) clk = ~clk;

   typedef struct {
      string       tag;
      bit          is_read;
      logic [31:0] exp_rd;
      logic [31:0] exp_pend;
      logic        exp_any;
      logic [4:0]  exp_idx;
      logic        exp_irq;
   } item_t;

   item_t sbq[$];
   event  chk_ev;
   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // Reference state built from the requirements
   logic [31:0] m_stat = '0;
   logic [31:0] m_mask = '0;
   logic        m_en = 1'b0;

   function automatic logic [31:0] model_read(input logic [9:0] a);
      if (a == W_STAT)      return m_stat;
      else if (a == W_MASK) return m_mask;
      else if (a == W_GEN)  return {31'b0, m_en};
      else                  return '0;
   endfunction

   // Monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(chk_ev);
         while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            if (it.is_read) begin
               n_checks++;
               if (reg_rdata !== it.exp_rd) begin
                  n_fail++;
                  $display("FAIL %s: rdata got %h expected %h", it.tag, reg_rdata, it.exp_rd);
               end
            end else begin
               n_checks++;
               if (pend_vec !== it.exp_pend || pend_any !== it.exp_any ||
                   pend_idx !== it.exp_idx || irq_out !== it.exp_irq) begin
                  n_fail++;
                  $display("FAIL %s: pend/any/idx/irq got %h/%b/%0d/%b expected %h/%b/%0d/%b",
                           it.tag, pend_vec, pend_any, pend_idx, irq_out,
                           it.exp_pend, it.exp_any, it.exp_idx, it.exp_irq);
               end
            end
         end
      end
   end

   task automatic expect_out(input string tag);
      item_t it;
      logic [31:0] p;
      p = m_stat & m_mask;
      it.tag = tag;
      it.is_read = 1'b0;
      it.exp_rd = '0;
      it.exp_pend = p;
      it.exp_any = (p != '0);
      it.exp_idx = 5'(lowest_set(p));
      it.exp_irq = m_en && (p != '0);
      sbq.push_back(it);
      -> chk_ev;
      #1;
   endtask

   task automatic expect_rd(input logic [9:0] a, input string tag);
      item_t it;
      reg_addr = a;
      #1;
      it.tag = tag;
      it.is_read = 1'b1;
      it.exp_rd = model_read(a);
      it.exp_pend = '0;
      it.exp_any = 1'b0;
      it.exp_idx = '0;
      it.exp_irq = 1'b0;
      sbq.push_back(it);
      -> chk_ev;
      #1;
   endtask

   // Driver: one clock of stimulus, then the model follows the edge
   task automatic step(input logic [31:0] evt, input bit wr,
                       input logic [9:0] a, input logic [31:0] wd);
      @(negedge clk);
      src_evt = evt;
      reg_wr = wr;
      reg_addr = a;
      reg_wdata = wd;
      @(negedge clk);
      if (wr && a == W_STAT) m_stat = m_stat & ~wd;
      m_stat = m_stat | evt;
      if (wr && a == W_MASK) m_mask = wd;
      if (wr && a == W_GEN)  m_en = wd[0];
      src_evt = '0;
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_stat = '0;
      m_mask = '0;
      m_en = 1'b0;
      #1;
      expect_out("R1 outputs during reset");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 20000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      do_reset();
      expect_out("R1 outputs after reset");
      expect_rd(W_STAT, "R1 status zero");
      expect_rd(W_MASK, "R1 mask zero");
      expect_rd(W_GEN,  "R1 enable zero");

      // R2: INTA event latches, masked off so nothing pending
      step(32'h0200_0000, 0, W_STAT, '0);
      expect_rd(W_STAT, "R2 INTA latched at bit 25");
      expect_out("R6 masked source not pending");
      step('0, 0, W_STAT, '0);
      expect_rd(W_STAT, "R2 bit held after pulse");

      // R5 / R7: unmask INTA and abort, enable still off
      step('0, 1, W_MASK, 32'h0600_0000);
      expect_rd(W_MASK, "R5 mask readback");
      expect_out("R7 pending but enable off");

      // R5: only bit 0 of the enable register is kept
      step('0, 1, W_GEN, 32'hFFFF_FFFF);
      expect_rd(W_GEN, "R5 enable reads bit0 only");
      expect_out("R7 line high with enable on");

      // R8: abort joins, INTA still wins
      step(32'h0400_0000, 0, W_STAT, '0);
      expect_out("R8 INTA ahead of abort");

      // R3: clear INTA only
      step('0, 1, W_STAT, 32'h0200_0000);
      expect_rd(W_STAT, "R3 one clears, zero keeps");
      expect_out("R8 abort index after INTA clear");

      // R7: enable off drops the line
      step('0, 1, W_GEN, 32'h0);
      expect_out("R7 enable off gates line");
      step('0, 1, W_GEN, 32'h1);
      expect_out("R7 enable back on");

      // R4: set beats clear on the abort bit
      step(32'h0400_0000, 1, W_STAT, 32'h0400_0000);
      expect_rd(W_STAT, "R4 set wins over clear");
      expect_out("R4 line stays up");

      // R3 / R8: clear everything
      step('0, 1, W_STAT, 32'hFFFF_FFFF);
      expect_rd(W_STAT, "R3 clear all");
      expect_out("R8 idle index zero");

      // R2 / R8: descriptor bits
      step('0, 1, W_MASK, 32'hFFFF_FFFF);
      step(32'h0000_0010, 0, W_STAT, '0);
      expect_out("R8 descriptor bit 4 alone");
      step(32'h0000_0004, 0, W_STAT, '0);
      expect_out("R8 descriptor bit 2 below 4");
      step(32'h0200_001F, 0, W_STAT, '0);
      expect_out("R8 descriptor bit 0 wins over all");
      expect_rd(W_STAT, "R2 several bits in one cycle");

      // R3: writing ones to clear bits never sets others
      step('0, 1, W_STAT, 32'h8000_0001);
      expect_rd(W_STAT, "R3 write one does not set");

      // R9: unmapped address
      step('0, 1, W_VOID, 32'hFFFF_FFFF);
      expect_rd(W_VOID, "R9 unmapped reads zero");
      expect_rd(W_MASK, "R9 mask untouched");
      expect_rd(W_STAT, "R9 status untouched");
      expect_rd(W_GEN,  "R9 enable untouched");
      step('0, 1, 10'h000, 32'h0000_0000);
      expect_rd(W_MASK, "R9 write at zero ignored");

      // R4: held level survives repeated clears
      for (int k = 0; k < 3; k++) begin
         step(32'h0200_0000, 1, W_STAT, 32'h0200_0000);
      end
      expect_rd(W_STAT, "R4 level source kept under clears");
      step('0, 1, W_STAT, 32'hFFFF_FFFF);
      expect_out("R7 line low once all cleared");

      // R1: reset in mid-run
      step(32'h0400_0000, 0, W_STAT, '0);
      do_reset();
      expect_out("R1 outputs after second reset");
      expect_rd(W_MASK, "R1 mask cleared by reset");
      expect_rd(W_GEN,  "R1 enable cleared by reset");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule